// File: doc/BRIEF.md
# Receive Frame DMA Writer

This block moves received Ethernet frames from a byte stream into system memory. Software arms entries in a small ring of receive descriptors. Each entry holds a buffer pointer, an interrupt-request flag and a wrap flag. The engine waits at the descriptor the ring head points to. When that descriptor is armed, the engine takes one frame from the stream and packs its bytes into 32-bit words. It writes the words to the buffer as single Wishbone write cycles. It then adds a constant 4-byte stand-in for the frame check sequence, stores the length and error status in the descriptor, hands the descriptor back and moves the head.

The stream source carries no CRC, so none is computed or checked. The block never discards a frame for lack of space. While the head descriptor is not armed, `s_ready` stays low and the source waits. There is no minimum frame length and no short-frame status. A frame of any length down to one byte is stored exactly as it arrived.

Stream rules: a byte moves on a rising edge where `s_valid` and `s_ready` are both high. `s_last` marks the final byte of a frame. The source must hold `s_valid`, `s_data` and `s_last` steady until the byte is taken. `s_ready` is low in these cases: while no armed descriptor waits at the head, during a bus write, during the optional idle cycle after a write, while the stand-in check bytes are being packed, and while the descriptor is being completed.

Top module: `rxdma_engine`

## Requirements
- R1: Payload byte k of a frame lands at buffer pointer + k. Bytes are packed little-endian: byte lane i is `m_dat[8i+7:8i]`, enabled by `m_sel[i]`, and words go to consecutive aligned addresses.
- R2: Directly after the last payload byte, the bytes 0xDE, 0xAD, 0xF0, 0x0D are stored in that order. The length reported in status bits [31:16] is the payload length plus 4.
- R3: The last word of a frame, when partial, enables only the lanes that hold frame bytes. Memory beyond the frame end in that word is left untouched.
- R4: While the head descriptor is not armed, `s_ready` stays low, no bus cycle starts and no byte is lost. Once the head descriptor is armed, the waiting frame is stored intact. `s_ready` is never high while `m_cyc` is high.
- R5: On completion the descriptor's armed bit (status bit 15) clears and its interrupt bit (14) and wrap bit (13) read back unchanged. The head then moves to the next index, or to index 0 if the wrap bit was set or the head was the last index.
- R6: `rx_irq` pulses for exactly one cycle per completed frame, and only when the descriptor's interrupt bit is set and `irq_en` is high.
- R7: Every bus address has its low two bits at zero. If an armed descriptor's pointer is misaligned, the frame is consumed with no bus cycle, status bit 1 is set and the length reads 0.
- R8: With `INSERT_WAIT_STATE` set (the default), `m_cyc` stays low for one extra cycle after every completed word write. With a stream that is never idle, consecutive writes of one frame start 6 cycles apart. Each write ends in the cycle after the slave acknowledges it.
- R9: If the slave answers a write with `m_err`, the engine issues no further writes for that frame. It drains the rest of the frame from the stream, sets status bit 0 and reports length 0. The next frame is handled normally.
- R10: Frames of 1 to 9 bytes, and frames of 42 and 43 bytes, are stored byte for byte, with no padding and no short-frame indication.
- R11: After reset no descriptor is armed: every status word reads 0, `s_ready`, `m_cyc` and `rx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Global enable for the receive interrupt |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Engine takes the byte on this edge |
| cfg_we | input | 1 | Arm descriptor `cfg_idx` |
| cfg_idx | input | $clog2(DESC_COUNT) | Descriptor to arm |
| cfg_ptr | input | 32 | Buffer pointer for the armed descriptor |
| cfg_irq | input | 1 | Interrupt-request flag for the armed descriptor |
| cfg_wrap | input | 1 | Wrap flag: last descriptor of the ring |
| stat_idx | input | $clog2(DESC_COUNT) | Descriptor selected for status readback |
| stat_word | output | 32 | {len[15:0], armed, irq, wrap, 11'b0, misaligned, bus error} |
| m_cyc | output | 1 | Bus cycle |
| m_stb | output | 1 | Bus strobe |
| m_we | output | 1 | Write enable (always 1) |
| m_adr | output | 32 | Byte address, word aligned |
| m_sel | output | 4 | Byte lane enables |
| m_dat | output | 32 | Write data |
| m_ack | input | 1 | Slave acknowledge |
| m_err | input | 1 | Slave error |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The hardest states to reach from the ports are the ones the engine enters after something goes wrong partway through a frame. One is a bus error on the second word of a frame while payload bytes are still arriving. Another is a source that has already presented a frame while no descriptor is armed. The bench reaches the first by having its memory model answer with an error at one chosen address. It reaches the second by starting the frame in parallel with a delay before the head descriptor is armed. In both cases it then checks memory, status and the bus-write count before it sends the next frame.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam logic [31:0] STANDIN_FCS = 32'hDEADF00D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE,
    ST_GAP,
    ST_DRAIN,
    ST_STATUS
  } rx_state_t;

  typedef struct packed {
    logic [15:0] len;
    logic        armed;
    logic        irq;
    logic        wrap;
    logic        bad_align;
    logic        bad_bus;
    logic [31:0] ptr;
  } rx_desc_t;
endpackage

// File: rtl/rxdma_desc_table.sv
module rxdma_desc_table
  import rxdma_pkg::*;
#(
  parameter int DESC_COUNT = 4,
  parameter int IDXW = $clog2(DESC_COUNT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [IDXW-1:0] host_idx,
  input  logic [31:0]     host_ptr,
  input  logic            host_irq,
  input  logic            host_wrap,
  input  logic            upd_we,
  input  logic [IDXW-1:0] upd_idx,
  input  logic [15:0]     upd_len,
  input  logic            upd_bad_align,
  input  logic            upd_bad_bus,
  input  logic [IDXW-1:0] hd_idx,
  output logic            hd_armed,
  output logic            hd_irq,
  output logic            hd_wrap,
  output logic [31:0]     hd_ptr,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_word
);
  rx_desc_t tbl [DESC_COUNT];

  for (genvar g = 0; g < DESC_COUNT; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[g] <= '0;
      end else if (upd_we && upd_idx == IDXW'(g)) begin
        tbl[g].len       <= upd_len;
        tbl[g].armed     <= 1'b0;
        tbl[g].bad_align <= upd_bad_align;
        tbl[g].bad_bus   <= upd_bad_bus;
      end else if (host_we && host_idx == IDXW'(g)) begin
        tbl[g].len       <= '0;
        tbl[g].armed     <= 1'b1;
        tbl[g].irq       <= host_irq;
        tbl[g].wrap      <= host_wrap;
        tbl[g].bad_align <= 1'b0;
        tbl[g].bad_bus   <= 1'b0;
        tbl[g].ptr       <= host_ptr;
      end
    end
  end

  always_comb begin
    hd_armed = tbl[hd_idx].armed;
    hd_irq   = tbl[hd_idx].irq;
    hd_wrap  = tbl[hd_idx].wrap;
    hd_ptr   = tbl[hd_idx].ptr;
    rd_word  = {tbl[rd_idx].len, tbl[rd_idx].armed, tbl[rd_idx].irq,
                tbl[rd_idx].wrap, 11'b0, tbl[rd_idx].bad_align,
                tbl[rd_idx].bad_bus};
  end
endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
  parameter int DW = 32,
  parameter int LANES = DW / 8,
  parameter int CW = $clog2(LANES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  output logic [DW-1:0] word,
  output logic [LANES-1:0] sel,
  output logic [CW-1:0] fill
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word <= '0;
      sel  <= '0;
      fill <= '0;
    end else if (push) begin
      word[8*fill[CW-2:0] +: 8] <= din;
      sel[fill[CW-2:0]]         <= 1'b1;
      fill                      <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int DESC_COUNT = 4,
  parameter bit INSERT_WAIT_STATE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          irq_en,
  input  logic                          s_valid,
  input  logic [7:0]                    s_data,
  input  logic                          s_last,
  output logic                          s_ready,
  input  logic                          cfg_we,
  input  logic [$clog2(DESC_COUNT)-1:0] cfg_idx,
  input  logic [31:0]                   cfg_ptr,
  input  logic                          cfg_irq,
  input  logic                          cfg_wrap,
  input  logic [$clog2(DESC_COUNT)-1:0] stat_idx,
  output logic [31:0]                   stat_word,
  output logic                          m_cyc,
  output logic                          m_stb,
  output logic                          m_we,
  output logic [31:0]                   m_adr,
  output logic [3:0]                    m_sel,
  output logic [31:0]                   m_dat,
  input  logic                          m_ack,
  input  logic                          m_err,
  output logic                          rx_irq
);
  localparam int IDXW  = $clog2(DESC_COUNT);
  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int CW    = $clog2(LANES) + 1;

  rx_state_t       state;
  logic [IDXW-1:0] head;
  logic [31:0]     addr;
  logic [15:0]     count;
  logic            fcs_phase, last_word, bad_bus, bad_align, irq_q;
  logic [1:0]      fcs_idx;

  logic            hd_armed, hd_irq, hd_wrap;
  logic [31:0]     hd_ptr;
  logic            push, pk_clr;
  logic [7:0]      push_byte;
  logic [DW-1:0]   pk_word;
  logic [LANES-1:0] pk_sel;
  logic [CW-1:0]   pk_fill;
  logic [IDXW-1:0] head_next;

  rxdma_desc_table #(.DESC_COUNT(DESC_COUNT), .IDXW(IDXW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .host_we(cfg_we), .host_idx(cfg_idx), .host_ptr(cfg_ptr),
    .host_irq(cfg_irq), .host_wrap(cfg_wrap),
    .upd_we(state == ST_STATUS), .upd_idx(head),
    .upd_len((bad_bus || bad_align) ? 16'd0 : count),
    .upd_bad_align(bad_align), .upd_bad_bus(bad_bus),
    .hd_idx(head), .hd_armed(hd_armed), .hd_irq(hd_irq),
    .hd_wrap(hd_wrap), .hd_ptr(hd_ptr),
    .rd_idx(stat_idx), .rd_word(stat_word)
  );

  rxdma_packer #(.DW(DW), .LANES(LANES), .CW(CW)) u_packer (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(push), .din(push_byte),
    .word(pk_word), .sel(pk_sel), .fill(pk_fill)
  );

  always_comb begin
    s_ready   = (state == ST_FILL && !fcs_phase) || state == ST_DRAIN;
    push      = state == ST_FILL && (fcs_phase || s_valid);
    push_byte = fcs_phase ? STANDIN_FCS[8*(3-fcs_idx) +: 8] : s_data;
    pk_clr    = state == ST_IDLE || (state == ST_WRITE && (m_ack || m_err));
    m_cyc     = state == ST_WRITE;
    m_stb     = state == ST_WRITE;
    m_we      = 1'b1;
    m_adr     = addr;
    m_sel     = pk_sel;
    m_dat     = pk_word;
    rx_irq    = irq_q;
    head_next = (hd_wrap || head == IDXW'(DESC_COUNT - 1)) ? '0 : head + 1'b1;
  end

  rx_state_t after_word;
  if (INSERT_WAIT_STATE) begin : g_gap
    assign after_word = ST_GAP;
  end else begin : g_nogap
    assign after_word = ST_FILL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      head      <= '0;
      addr      <= '0;
      count     <= '0;
      fcs_phase <= 1'b0;
      fcs_idx   <= '0;
      last_word <= 1'b0;
      bad_bus   <= 1'b0;
      bad_align <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= (state == ST_STATUS) && hd_irq && irq_en;
      case (state)
        ST_IDLE: if (hd_armed) begin
          addr      <= hd_ptr;
          count     <= '0;
          fcs_phase <= 1'b0;
          fcs_idx   <= '0;
          last_word <= 1'b0;
          bad_bus   <= 1'b0;
          bad_align <= hd_ptr[1:0] != 2'b00;
          state     <= (hd_ptr[1:0] != 2'b00) ? ST_DRAIN : ST_FILL;
        end
        ST_FILL: if (push) begin
          count <= count + 1'b1;
          if (fcs_phase) fcs_idx <= fcs_idx + 1'b1;
          else if (s_last) fcs_phase <= 1'b1;
          if (fcs_phase && fcs_idx == 2'd3) begin
            last_word <= 1'b1;
            state     <= ST_WRITE;
          end else if (pk_fill == CW'(LANES - 1)) begin
            state <= ST_WRITE;
          end
        end
        ST_WRITE: if (m_err) begin
          bad_bus <= 1'b1;
          state   <= fcs_phase ? ST_STATUS : ST_DRAIN;
        end else if (m_ack) begin
          addr  <= addr + 32'd4;
          state <= last_word ? ST_STATUS : after_word;
        end
        ST_GAP:   state <= ST_FILL;
        ST_DRAIN: if (s_valid && s_last) state <= ST_STATUS;
        ST_STATUS: begin
          head  <= head_next;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxdma_engine_chk.sv
module rxdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_ready,
  input logic        m_cyc,
  input logic        m_ack,
  input logic        m_err,
  input logic [31:0] m_adr,
  input logic [31:0] m_dat,
  input logic [3:0]  m_sel,
  input logic        rx_irq
);
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_cyc |-> m_adr[1:0] == 2'b00);

  assert_no_accept_on_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_cyc |-> !s_ready);

  assert_lanes_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_cyc |-> (m_sel == 4'b0001 || m_sel == 4'b0011 ||
               m_sel == 4'b0111 || m_sel == 4'b1111));

  assert_cycle_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_cyc && (m_ack || m_err) |=> !m_cyc);

  assert_hold_until_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_cyc && !m_ack && !m_err |=> m_cyc && $stable(m_adr) && $stable(m_dat) && $stable(m_sel));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
endmodule

bind rxdma_engine rxdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_cyc(m_cyc),
  .m_ack(m_ack), .m_err(m_err), .m_adr(m_adr), .m_dat(m_dat),
  .m_sel(m_sel), .rx_irq(rx_irq)
);

// File: tb/rxdma_engine_bench.sv
module rxdma_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        irq_en = 1'b0, s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic        cfg_we = 1'b0, cfg_irq = 1'b0, cfg_wrap = 1'b0;
  logic [1:0]  cfg_idx = '0, stat_idx = '0;
  logic [31:0] cfg_ptr = '0, stat_word;
  logic        m_cyc, m_stb, m_we, m_ack = 1'b0, m_err = 1'b0, rx_irq;
  logic [31:0] m_adr, m_dat;
  logic [3:0]  m_sel;

  rxdma_engine u_rxdma_engine (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ptr(cfg_ptr),
    .cfg_irq(cfg_irq), .cfg_wrap(cfg_wrap),
    .stat_idx(stat_idx), .stat_word(stat_word),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr),
    .m_sel(m_sel), .m_dat(m_dat), .m_ack(m_ack), .m_err(m_err),
    .rx_irq(rx_irq)
  );

  int checks = 0, errors = 0;
  int cyc_n = 0, bus_writes = 0, irq_count = 0;
  int first_cyc = -1, last_cyc = -1;
  logic [7:0] mem [0:1023];
  logic        err_arm = 1'b0;
  logic [31:0] err_adr = '0;
  int head = 0;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  // memory slave and monitors, all acting at the falling edge
  initial forever begin
    @(negedge clk);
    if (rx_irq) irq_count++;
    if (m_cyc) begin
      if (first_cyc < 0) first_cyc = cyc_n;
      last_cyc = cyc_n;
    end
    if (m_cyc && m_stb && !m_ack && !m_err) begin
      if (err_arm && m_adr == err_adr) m_err = 1'b1;
      else begin
        for (int b = 0; b < 4; b++)
          if (m_sel[b]) mem[(m_adr[9:0] & 10'h3FC) + 10'(b)] = m_dat[8*b +: 8];
        m_ack = 1'b1;
        bus_writes++;
      end
    end else begin
      m_ack = 1'b0;
      m_err = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors + 0 * checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 31 + k * 7 + 3) & 255);
  endfunction

  task automatic arm(input int idx, input logic [31:0] ptr, input logic irqf, input logic wrapf);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_ptr = ptr; cfg_irq = irqf; cfg_wrap = wrapf;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = pat(seed, k); s_last = (k == len - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_done(input int idx, input string req);
    int t;
    @(negedge clk);
    stat_idx = 2'(idx);
    @(negedge clk);
    t = 0;
    while (stat_word[15] && t < 3000) begin @(negedge clk); t++; end
    chk(!stat_word[15], req, "descriptor released", stat_word[15], 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic preset(input int base, input int n);
    for (int a = 0; a < n; a++) mem[base + a] = 8'h55;
  endtask

  // full good frame: arm, send, check memory, status and interrupt
  task automatic good_frame(input int len, input int seed, input logic irqf, input logic wrapf);
    int base, ic, tail, ok;
    logic [7:0] fcs [4];
    fcs[0] = 8'hDE; fcs[1] = 8'hAD; fcs[2] = 8'hF0; fcs[3] = 8'h0D;
    base = head * 128;
    preset(base, len + 12);
    ic = irq_count;
    arm(head, 32'(base), irqf, wrapf);
    send_frame(len, seed);
    wait_done(head, "R5");
    ok = 1;
    for (int k = 0; k < len; k++) if (mem[base + k] !== pat(seed, k)) ok = 0;
    chk(ok == 1, (len <= 9 || len >= 42) ? "R10" : "R1", "payload bytes", len, len);
    for (int k = 0; k < 4; k++)
      chk(mem[base + len + k] === fcs[k], "R2", "appended byte", mem[base + len + k], fcs[k]);
    tail = (len + 4) % 4;
    ok = 1;
    if (tail != 0) for (int a = len + 4; a < len + 8 - tail; a++) if (mem[base + a] !== 8'h55) ok = 0;
    chk(ok == 1 && mem[base + ((len + 7) / 4) * 4] === 8'h55, "R3", "bytes past frame untouched", ok, 1);
    chk(stat_word[31:16] == 16'(len + 4), "R2", "reported length", stat_word[31:16], len + 4);
    chk(stat_word[14] == irqf && stat_word[13] == wrapf && stat_word[1:0] == 2'b00,
        "R5", "flags kept, no error", stat_word[15:0], {irqf, wrapf, 13'b0});
    chk(irq_count - ic == ((irqf && irq_en) ? 1 : 0), "R6", "interrupt pulses",
        irq_count - ic, (irqf && irq_en) ? 1 : 0);
    head = (wrapf || head == 3) ? 0 : head + 1;
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'h55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(s_ready == 1'b0, "R11", "s_ready after reset", s_ready, 0);
    chk(m_cyc == 1'b0 && rx_irq == 1'b0, "R11", "bus and irq idle", {m_cyc, rx_irq}, 0);
    for (int i = 0; i < 4; i++) begin
      stat_idx = 2'(i);
      @(negedge clk);
      chk(stat_word == 32'h0, "R11", "status after reset", stat_word, 0);
    end
    irq_en = 1'b1;

    // length sweep: R1 R2 R3 R10
    for (int len = 1; len <= 9; len++) good_frame(len, len, 1'b1, 1'b0);
    good_frame(42, 42, 1'b1, 1'b0);
    good_frame(43, 43, 1'b1, 1'b0);

    // R8 spacing: 12 payload + 4 appended = 4 writes, 6 cycles apart
    first_cyc = -1; last_cyc = -1;
    good_frame(12, 99, 1'b1, 1'b0);
    chk(last_cyc - first_cyc == 18, "R8", "first-to-last write span", last_cyc - first_cyc, 18);

    // R6 suppression cases
    good_frame(5, 7, 1'b0, 1'b0);
    irq_en = 1'b0;
    good_frame(6, 8, 1'b1, 1'b0);
    irq_en = 1'b1;

    // R5 wrap: wrap at index 1, then both 0 and 2 armed; frame must land in 0
    while (head != 1) good_frame(4, 11, 1'b0, 1'b0);
    good_frame(3, 12, 1'b0, 1'b1);
    chk(head == 0, "R5", "bench head after wrap", head, 0);
    arm(2, 32'd256, 1'b0, 1'b0);
    good_frame(7, 13, 1'b0, 1'b0);
    stat_idx = 2'd2;
    @(negedge clk);
    chk(stat_word[15] == 1'b1, "R5", "index 2 skipped by wrap, still armed", stat_word[15], 1);
    good_frame(2, 14, 1'b0, 1'b0);
    good_frame(2, 15, 1'b0, 1'b0);

    // R4 back-pressure with no armed descriptor
    begin
      int bw, base;
      bw = bus_writes;
      base = head * 128;
      preset(base, 20);
      fork
        send_frame(5, 21);
        begin
          repeat (20) @(negedge clk);
          chk(s_ready == 1'b0, "R4", "ready held low", s_ready, 0);
          chk(bus_writes == bw, "R4", "no bus writes while unarmed", bus_writes - bw, 0);
          arm(head, 32'(base), 1'b0, 1'b0);
        end
      join
      wait_done(head, "R4");
      for (int k = 0; k < 5; k++)
        chk(mem[base + k] === pat(21, k), "R4", "stalled frame byte", mem[base + k], pat(21, k));
      chk(stat_word[31:16] == 16'd9, "R4", "stalled frame length", stat_word[31:16], 9);
      head = (head == 3) ? 0 : head + 1;
    end

    // R7 misaligned pointer
    begin
      int bw;
      bw = bus_writes;
      arm(head, 32'(head * 128 + 2), 1'b0, 1'b0);
      send_frame(6, 31);
      wait_done(head, "R7");
      chk(bus_writes == bw, "R7", "no bus write for misaligned buffer", bus_writes - bw, 0);
      chk(stat_word[1] == 1'b1 && stat_word[31:16] == 16'd0, "R7", "misaligned status",
          stat_word, 32'h2);
      head = (head == 3) ? 0 : head + 1;
    end

    // R9 bus error on second word
    begin
      int bw, base;
      bw = bus_writes;
      base = head * 128;
      preset(base, 20);
      err_adr = 32'(base + 4);
      err_arm = 1'b1;
      arm(head, 32'(base), 1'b0, 1'b0);
      send_frame(10, 41);
      wait_done(head, "R9");
      err_arm = 1'b0;
      chk(bus_writes - bw == 1, "R9", "writes before abort", bus_writes - bw, 1);
      chk(stat_word[0] == 1'b1 && stat_word[31:16] == 16'd0, "R9", "bus error status",
          stat_word, 32'h1);
      chk(mem[base + 8] === 8'h55 && mem[base + 4] === 8'h55, "R9", "nothing after error",
          mem[base + 8], 8'h55);
      head = (head == 3) ? 0 : head + 1;
      good_frame(11, 42, 1'b1, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule